// File: doc/BRIEF.md
# Dual-Channel Selectable Output Limiter

This block bounds the output sample of two independent filter channels, A and B. Each channel owns a bank of sixteen limit words. Every limit word packs a signed lower bound and a signed upper bound. With each sample, a 4-bit select input per channel picks which limit word of that channel's bank applies. The two channels can therefore use different limits on every sample.

A control word holds one limiting enable per channel. When a channel's enable is clear, its sample passes through unchanged. When the enable is set, a sample above the chosen upper bound becomes the upper bound, and a sample below the chosen lower bound becomes the lower bound. The limit words and the control word are loaded through a plain single-cycle write port that takes an address and a data word.

The result is registered, and a valid flag travels with it.

Top module: `dual_limiter`

## Requirements
- R1: After reset, outValid is 0, outA and outB are 0, both enables are 0 and every limit word is zero.
- R2: outValid equals the inValid that was presented one clock earlier, and a valid sample's result appears on outA/outB on that same edge, one cycle after the sample is presented.
- R3: With a channel's enable at 0, that channel's output equals its input sample, whatever the selected limit word holds.
- R4: With the enable at 1, a sample greater than the selected upper bound (bits 31:16 of the limit word, signed 16-bit) is output as that upper bound.
- R5: With the enable at 1, a sample less than the selected lower bound (bits 15:0 of the limit word, signed 16-bit), and not above the upper bound, is output as that lower bound. A sample inside both bounds is output unchanged.
- R6: When the lower bound is greater than the upper bound, the upper-bound comparison is made first. A sample above the upper bound gives the upper bound. Any other sample below the lower bound gives the lower bound.
- R7: selA picks limit word selA of bank A and selB picks limit word selB of bank B, independently, on every sample.
- R8: A write with wrEn=1 decodes wrAddr as follows: 0..15 writes bank A word wrAddr, 16..31 writes bank B word wrAddr-16, and 32 writes the control word.
- R9: Control word bit 0 is the channel B enable and bit 1 is the channel A enable. Each channel obeys only its own bit.
- R10: A write with wrEn=0, or with wrAddr in 33..63, changes no limit word and no enable. Control data bits 31:2 have no effect.
- R11: While inValid is 0, outA and outB hold their previous values.
- R12: A write affects samples presented from the next cycle onward. A sample presented in the same cycle as a write uses the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 6 | Write address (bank A, bank B, control) |
| wrData | input | 32 | Write data; bits 31:16 upper bound, 15:0 lower bound |
| inValid | input | 1 | Input samples are valid |
| sampleA | input | 16 | Channel A sample, signed |
| sampleB | input | 16 | Channel B sample, signed |
| selA | input | 4 | Limit word select for channel A |
| selB | input | 4 | Limit word select for channel B |
| outValid | output | 1 | Output samples are valid |
| outA | output | 16 | Channel A result, signed |
| outB | output | 16 | Channel B result, signed |

## Verification
Every result is due exactly one clock after its stimulus. The clamped samples and outValid appear on the edge that captures the inputs. A write lands on the edge that captures it, so its effect shows on the samples of the following cycle. The bench drives each step at a falling edge and samples the outputs 1 ns after the next rising edge. Its reference model computes the expected result from the limit and enable contents held before that step's write, and only afterwards applies the write, so the same-cycle and next-cycle ordering is checked directly.

// File: rtl/limiter_pkg.sv
package limiter_pkg;
  parameter int SAMPLE_W = 16;
  parameter int NUM_LIM  = 16;
  parameter int SEL_W    = $clog2(NUM_LIM);
  parameter int WORD_W   = 2 * SAMPLE_W;
  parameter int ADDR_W   = SEL_W + 2;
  parameter int NUM_CH   = 2;

  // Strobes from the write decoder to the storage and datapath
  typedef struct packed {
    logic [NUM_LIM-1:0] wrBankA;
    logic [NUM_LIM-1:0] wrBankB;
    logic               wrCtrl;
    logic [WORD_W-1:0]  data;
  } ctrlStrobes_t;
endpackage

// File: rtl/limit_ctrl.sv
module limit_ctrl
  import limiter_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [WORD_W-1:0]  wrData,
  output ctrlStrobes_t       strobes,
  output logic               enA,
  output logic               enB
);
  localparam int CTRL_ADDR = 2 * NUM_LIM;

  logic isBank;
  logic isChB;
  logic [SEL_W-1:0] idx;

  assign isBank = ~wrAddr[ADDR_W-1];
  assign isChB  = wrAddr[SEL_W];
  assign idx    = wrAddr[SEL_W-1:0];

  always_comb begin
    strobes = '0;
    strobes.data = wrData;
    if (wrEn) begin
      if (isBank) begin
        if (isChB) strobes.wrBankB[idx] = 1'b1;
        else       strobes.wrBankA[idx] = 1'b1;
      end else if (wrAddr == ADDR_W'(CTRL_ADDR)) begin
        strobes.wrCtrl = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enA <= 1'b0;
      enB <= 1'b0;
    end else if (strobes.wrCtrl) begin
      enB <= wrData[0];
      enA <= wrData[1];
    end
  end

  // R8: at most one target per write
  a_r8_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrBankA, strobes.wrBankB, strobes.wrCtrl}));

  // R10: enables change only after a control write
  a_r10_enable_stable: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strobes.wrCtrl)) |-> ($stable(enA) && $stable(enB)));

  // R8: no strobe when the write strobe is low
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> ($countones({strobes.wrBankA, strobes.wrBankB, strobes.wrCtrl}) == 0));
endmodule

// File: rtl/limit_bank.sv
module limit_bank
  import limiter_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_LIM-1:0]         wrStrobe,
  input  logic [WORD_W-1:0]          wrData,
  input  logic [SEL_W-1:0]           sel,
  output logic signed [SAMPLE_W-1:0] lowerLim,
  output logic signed [SAMPLE_W-1:0] upperLim
);
  logic [WORD_W-1:0] limReg [NUM_LIM];

  for (genvar i = 0; i < NUM_LIM; i++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            limReg[i] <= '0;
      else if (wrStrobe[i]) limReg[i] <= wrData;
    end

    // R10: a word changes only when its own strobe fired
    a_r10_word_hold: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !$past(wrStrobe[i])) |-> $stable(limReg[i]));
  end

  logic [WORD_W-1:0] chosen;
  assign chosen   = limReg[sel];
  assign lowerLim = chosen[SAMPLE_W-1:0];
  assign upperLim = chosen[WORD_W-1:SAMPLE_W];
endmodule

// File: rtl/clamp_datapath.sv
module clamp_datapath
  import limiter_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic                       en,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [SAMPLE_W-1:0] lowerLim,
  input  logic signed [SAMPLE_W-1:0] upperLim,
  output logic signed [SAMPLE_W-1:0] outData
);
  logic signed [SAMPLE_W-1:0] nextData;

  always_comb begin
    if (!en)                    nextData = sample;
    else if (sample > upperLim) nextData = upperLim;
    else if (sample < lowerLim) nextData = lowerLim;
    else                        nextData = sample;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        outData <= '0;
    else if (inValid) outData <= nextData;
  end

  // R11: hold while no valid sample
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(inValid)) |-> $stable(outData));

  // R3: disabled channel passes the sample
  a_r3_passthru: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && !$past(en)) |-> (outData == $past(sample)));

  // R4 / R5: enabled with ordered bounds stays inside them
  a_r4_bounded: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && $past(en) && ($past(lowerLim) <= $past(upperLim)))
      |-> ((outData <= $past(upperLim)) && (outData >= $past(lowerLim))));

  // R6: above the upper bound always yields the upper bound
  a_r6_upper_wins: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && $past(en) && ($past(sample) > $past(upperLim)))
      |-> (outData == $past(upperLim)));
endmodule

// File: rtl/dual_limiter.sv
module dual_limiter
  import limiter_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [WORD_W-1:0]          wrData,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] sampleA,
  input  logic signed [SAMPLE_W-1:0] sampleB,
  input  logic [SEL_W-1:0]           selA,
  input  logic [SEL_W-1:0]           selB,
  output logic                       outValid,
  output logic signed [SAMPLE_W-1:0] outA,
  output logic signed [SAMPLE_W-1:0] outB
);
  ctrlStrobes_t strobes;
  logic enA;
  logic enB;

  limit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobes(strobes), .enA(enA), .enB(enB)
  );

  logic [NUM_LIM-1:0]         chStrobe [NUM_CH];
  logic [SEL_W-1:0]           chSel    [NUM_CH];
  logic                       chEn     [NUM_CH];
  logic signed [SAMPLE_W-1:0] chSample [NUM_CH];
  logic signed [SAMPLE_W-1:0] chLower  [NUM_CH];
  logic signed [SAMPLE_W-1:0] chUpper  [NUM_CH];
  logic signed [SAMPLE_W-1:0] chOut    [NUM_CH];

  assign chStrobe[0] = strobes.wrBankA;
  assign chStrobe[1] = strobes.wrBankB;
  assign chSel[0]    = selA;
  assign chSel[1]    = selB;
  assign chEn[0]     = enA;
  assign chEn[1]     = enB;
  assign chSample[0] = sampleA;
  assign chSample[1] = sampleB;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    limit_bank u_bank (
      .clk(clk), .rstN(rstN), .wrStrobe(chStrobe[c]), .wrData(strobes.data),
      .sel(chSel[c]), .lowerLim(chLower[c]), .upperLim(chUpper[c])
    );
    clamp_datapath u_clamp (
      .clk(clk), .rstN(rstN), .inValid(inValid), .en(chEn[c]),
      .sample(chSample[c]), .lowerLim(chLower[c]), .upperLim(chUpper[c]),
      .outData(chOut[c])
    );
  end

  assign outA = chOut[0];
  assign outB = chOut[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2: valid flag trails the input by one cycle
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (outValid == $past(inValid)));
endmodule

// File: tb/dual_limiter_tb.sv
module dual_limiter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [5:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic inValid = 1'b0;
  logic signed [15:0] sampleA = '0, sampleB = '0;
  logic [3:0] selA = '0, selB = '0;
  logic outValid;
  logic signed [15:0] outA, outB;

  always #2.5 clk = ~clk;

  dual_limiter u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .inValid(inValid), .sampleA(sampleA), .sampleB(sampleB), .selA(selA), .selB(selB),
    .outValid(outValid), .outA(outA), .outB(outB)
  );

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  logic [31:0] mLimA [16];
  logic [31:0] mLimB [16];
  bit mEnA = 0, mEnB = 0;
  logic signed [15:0] expA = 0, expB = 0;

  function automatic logic signed [15:0] clampRef(input logic signed [15:0] s,
      input logic [31:0] w, input bit en);
    logic signed [15:0] lo, hi;
    lo = w[15:0];
    hi = w[31:16];
    if (!en) return s;
    if (s > hi) return hi;
    if (s < lo) return lo;
    return s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: optional write plus optional sample, checked after the edge
  task automatic step(input bit we, input logic [5:0] a, input logic [31:0] d,
      input bit v, input logic signed [15:0] sa, input logic signed [15:0] sb,
      input logic [3:0] la, input logic [3:0] lb, input string req);
    @(negedge clk);
    wrEn = we; wrAddr = a; wrData = d;
    inValid = v; sampleA = sa; sampleB = sb; selA = la; selB = lb;
    if (v) begin
      expA = clampRef(sa, mLimA[la], mEnA);
      expB = clampRef(sb, mLimB[lb], mEnB);
    end
    if (we) begin
      if (a < 16) mLimA[a[3:0]] = d;
      else if (a < 32) mLimB[a[3:0]] = d;
      else if (a == 32) begin mEnB = d[0]; mEnA = d[1]; end
    end
    @(posedge clk);
    #1;
    check({req, " valid"}, int'(outValid), int'(v));
    check({req, " A"}, int'(outA), int'(expA));
    check({req, " B"}, int'(outB), int'(expB));
    wrEn = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input string req);
    step(1, a, d, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    for (int i = 0; i < 16; i++) begin mLimA[i] = 0; mLimB[i] = 0; end
    #12;
    check("R1 reset valid", int'(outValid), 0);
    check("R1 reset A", int'(outA), 0);
    check("R1 reset B", int'(outB), 0);
    rstN = 1;
    // R1/R3: zero words, enables off -> pass-through
    step(0, 0, 0, 1, 16'sh7fff, -16'sd32768, 4'd0, 4'd9, "R1/R3 pass");
    // R8: bank A word 3 = upper 100, lower -50; bank B word 7 = upper 10, lower 0
    wr(6'd3, {16'd100, 16'hffce}, "R8 wrA");
    wr(6'd23, {16'd10, 16'd0}, "R8 wrB");
    // R3: still disabled, limits ignored
    step(0, 0, 0, 1, 16'sd500, 16'sd500, 4'd3, 4'd7, "R3 disabled");
    // R9: enable A only (bit 1)
    wr(6'd32, 32'h2, "R9 ctrl A");
    step(0, 0, 0, 1, 16'sd200, 16'sd200, 4'd3, 4'd7, "R4 R9 above");
    step(0, 0, 0, 1, -16'sd300, -16'sd300, 4'd3, 4'd7, "R5 below");
    step(0, 0, 0, 1, 16'sd20, 16'sd20, 4'd3, 4'd7, "R5 inside");
    // R9: enable B only (bit 0)
    wr(6'd32, 32'h1, "R9 ctrl B");
    step(0, 0, 0, 1, 16'sd200, 16'sd200, 4'd3, 4'd7, "R9 B only");
    // R10: upper data bits ignored -> both enables off
    wr(6'd32, 32'hffff_fffc, "R10 ctrl high");
    step(0, 0, 0, 1, 16'sd200, 16'sd200, 4'd3, 4'd7, "R10 high bits");
    wr(6'd32, 32'h3, "R9 both");
    // R6: lower 10 > upper -10
    wr(6'd5, {16'hfff6, 16'd10}, "R6 wr");
    step(0, 0, 0, 1, 16'sd0, 16'sd5, 4'd5, 4'd7, "R6 upper wins");
    step(0, 0, 0, 1, -16'sd20, -16'sd3, 4'd5, 4'd7, "R6 low side");
    // R10: ignored writes
    step(0, 6'd3, 32'h0, 0, 0, 0, 0, 0, "R10 wrEn low");
    wr(6'd40, 32'h0, "R10 addr 40");
    wr(6'd63, 32'h0, "R10 addr 63");
    step(0, 0, 0, 1, 16'sd200, 16'sd200, 4'd3, 4'd7, "R10 kept");
    // R11: hold
    step(0, 0, 0, 0, 16'sd1, 16'sd1, 4'd0, 4'd0, "R11 hold");
    // R12: same-cycle write uses old contents, next cycle new
    step(1, 6'd3, {16'd50, 16'd40}, 1, 16'sd90, 16'sd90, 4'd3, 4'd7, "R12 same cycle");
    step(0, 0, 0, 1, 16'sd90, 16'sd90, 4'd3, 4'd7, "R12 next cycle");
    // R7: different selects per channel
    wr(6'd16, {16'd1000, 16'hfc18}, "R7 wrB0");
    step(0, 0, 0, 1, 16'sd30000, 16'sd30000, 4'd5, 4'd0, "R7 select");
    // R2/R4-R7: random
    seed = 32'h1234_5678;
    void'($urandom(seed));
    for (int n = 0; n < 600; n++) begin
      bit we = ($urandom % 4) == 0;
      logic [5:0] a = ($urandom % 8 == 0) ? 6'd32 : 6'($urandom % 34);
      logic [31:0] d = $urandom;
      bit v = ($urandom % 5) != 0;
      step(we, a, d, v, 16'($urandom), 16'($urandom), 4'($urandom), 4'($urandom),
           "R2/R4/R5/R7 random");
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule